// File: doc/BRIEF.md
# Dual-Clock Sync and Reset Distributor

This block sits between the sync pins of a two-clock downconverter and the functions that respond to them. It has a front-end clock for the input and carrier stages and a back-end clock for filtering, gain and output. Three sync inputs arrive with no timing relation to either clock: one front-end sync, one back-end sync and one master sync. Each is brought into its domain and turned into single-cycle strobes. Software sets programmable enable vectors that decide which downstream action each sync event triggers.

A software reset command is issued in the front-end domain. It becomes a reset exactly ten cycles wide in each domain, so that no enable still in flight survives in a pipeline. A software sync command drives the device's master sync output. It also drives a sync output whose clock domain is chosen at run time, so that one device can act as the sync source for a group of devices. The carrier NCO, CIC, halfband, FIR, AGC and FIFO datapaths are not part of this block. They appear only as the strobe outputs that control them.

Top module: `dsc_sync_ctrl`

## Requirements
- R1: Each rising edge on `fe_sync_in` produces one pulse, one front-end cycle wide, on every bit of `fe_stb` whose `fe_en` bit is 1. Bits whose enable is 0 stay low. Holding the input high produces no further pulses. Bit map: 0 phase offset update, 1 center frequency update, 2 CIC counter reset, 3 NCO feedback clear, 4 carrier NCO load, 5 CIC load.
- R2: Each rising edge on `be_sync_in` produces one pulse, one back-end cycle wide, on every bit of `be_stb` whose `be_en` bit is 1. Bits whose enable is 0 stay low. Bit map: 0 halfband reset, 1 FIR reset, 2 resampler/halfband state machine reset, 3 output FIFO reset, 4 AGC gain load, 5 timing NCO load.
- R3: When `fe_sync_rst_en` is 1, a rising edge on `fe_sync_in` drives `fe_rst` high for exactly 10 front-end cycles. When it is 0, `fe_rst` does not respond to the sync input.
- R4: A one-cycle `sw_rst_req` drives `fe_rst` high for exactly 10 front-end cycles and `be_rst` high for exactly 10 back-end cycles, each as a single pulse.
- R5: A new reset request that arrives while `fe_rst` is high restarts its count. `fe_rst` then stays high until 10 cycles after the latest request.
- R6: Each one-cycle `sw_sync_req` produces one pulse on `sync_out`. The pulse is one front-end cycle wide when `cfg_sout_be` is 0 and one back-end cycle wide when `cfg_sout_be` is 1.
- R7: Each rising edge on `msync_in` produces one pulse, one cycle wide, on both `msync_fe_stb` (front-end clock) and `msync_be_stb` (back-end clock).
- R8: Each one-cycle `sw_sync_req` produces one pulse, one front-end cycle wide, on `msync_out`.
- R9: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fe_clk | input | 1 | Front-end clock |
| be_clk | input | 1 | Back-end processing clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_sout_be | input | 1 | Clock domain of sync_out: 0 front-end, 1 back-end |
| fe_en | input | FE_FN | Front-end sync action enables (bit map in R1) |
| fe_sync_rst_en | input | 1 | Front-end sync also triggers the stretched front-end reset |
| be_en | input | BE_FN | Back-end sync action enables (bit map in R2) |
| sw_rst_req | input | 1 | Software reset command, front-end domain, one cycle |
| sw_sync_req | input | 1 | Software sync command, front-end domain, one cycle |
| fe_sync_in | input | 1 | Asynchronous front-end sync input |
| be_sync_in | input | 1 | Asynchronous back-end sync input |
| msync_in | input | 1 | Asynchronous master sync input |
| fe_stb | output | FE_FN | Front-end action strobes |
| be_stb | output | BE_FN | Back-end action strobes |
| fe_rst | output | 1 | Stretched front-end reset |
| be_rst | output | 1 | Stretched back-end reset |
| msync_fe_stb | output | 1 | Master sync event strobe, front-end domain |
| msync_be_stb | output | 1 | Master sync event strobe, back-end domain |
| sync_out | output | 1 | Sync output, domain selected by cfg_sout_be |
| msync_out | output | 1 | Master sync output |

## Verification
On every cycle, the assertions check that no action strobe or master sync strobe lasts longer than one cycle in its domain. They also check that neither stretched reset ever ends before it has been high for the full count. Only the bench scenarios can show the behaviour that depends on stimulus. This covers the mapping from enable bits to strobes, and that a held input gives a single event. It also covers the exact reset widths in both clocks, the lengthened reset after a restart, and the domain of the sync output chosen by the configuration bit.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int DSC_MIN_STAGES = 2;
   typedef enum logic {SOUT_FE = 1'b0, SOUT_BE = 1'b1} sout_sel_e;
endpackage

// File: rtl/dsc_sync_edge.sv
module dsc_sync_edge #(
   parameter int STAGES     = 2,
   parameter bit BOTH_EDGES = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic evt
);
   logic [STAGES-1:0] sh;
   logic              last;

   if (STAGES < dsc_pkg::DSC_MIN_STAGES) begin : g_bad_stages
      $error("dsc_sync_edge: STAGES below minimum");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         last <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], d};
         last <= sh[STAGES-1];
      end
   end

   if (BOTH_EDGES) begin : g_toggle
      assign evt = sh[STAGES-1] ^ last;
   end else begin : g_rise
      assign evt = sh[STAGES-1] & ~last;
   end
endmodule

// File: rtl/dsc_pulse_xfer.sv
module dsc_pulse_xfer #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic dst_clk,
   input  logic rst_n,
   input  logic src_pulse,
   output logic dst_pulse
);
   logic tgl;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) tgl <= 1'b0;
      else if (src_pulse) tgl <= ~tgl;
   end

   dsc_sync_edge #(.STAGES(STAGES), .BOTH_EDGES(1'b1)) u_dst (
      .clk(dst_clk), .rst_n(rst_n), .d(tgl), .evt(dst_pulse)
   );
endmodule

// File: rtl/dsc_rst_stretch.sv
module dsc_rst_stretch #(
   parameter int CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic rst_out
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOADV = CW'(CYCLES);

   logic [CW-1:0] cnt;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("dsc_rst_stretch: CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= LOADV;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign rst_out = (cnt != '0);
endmodule

// File: rtl/dsc_sync_ctrl.sv
module dsc_sync_ctrl #(
   parameter int FE_FN       = 6,
   parameter int BE_FN       = 6,
   parameter int RST_CYCLES  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             fe_clk,
   input  logic             be_clk,
   input  logic             rst_n,
   input  logic             cfg_sout_be,
   input  logic [FE_FN-1:0] fe_en,
   input  logic             fe_sync_rst_en,
   input  logic [BE_FN-1:0] be_en,
   input  logic             sw_rst_req,
   input  logic             sw_sync_req,
   input  logic             fe_sync_in,
   input  logic             be_sync_in,
   input  logic             msync_in,
   output logic [FE_FN-1:0] fe_stb,
   output logic [BE_FN-1:0] be_stb,
   output logic             fe_rst,
   output logic             be_rst,
   output logic             msync_fe_stb,
   output logic             msync_be_stb,
   output logic             sync_out,
   output logic             msync_out
);
   import dsc_pkg::*;

   if (FE_FN < 1 || BE_FN < 1) begin : g_bad_fn
      $error("dsc_sync_ctrl: function counts must be positive");
   end

   logic fe_evt, msf_evt, be_evt, msb_evt;
   logic be_rst_load, be_sync_evt;
   logic fe_sout_q, be_sout_q;
   sout_sel_e sout_sel;

   // front-end domain event detection
   dsc_sync_edge #(.STAGES(SYNC_STAGES), .BOTH_EDGES(1'b0)) u_fe_sync (
      .clk(fe_clk), .rst_n(rst_n), .d(fe_sync_in), .evt(fe_evt));
   dsc_sync_edge #(.STAGES(SYNC_STAGES), .BOTH_EDGES(1'b0)) u_fe_msync (
      .clk(fe_clk), .rst_n(rst_n), .d(msync_in), .evt(msf_evt));

   // back-end domain event detection
   dsc_sync_edge #(.STAGES(SYNC_STAGES), .BOTH_EDGES(1'b0)) u_be_sync (
      .clk(be_clk), .rst_n(rst_n), .d(be_sync_in), .evt(be_evt));
   dsc_sync_edge #(.STAGES(SYNC_STAGES), .BOTH_EDGES(1'b0)) u_be_msync (
      .clk(be_clk), .rst_n(rst_n), .d(msync_in), .evt(msb_evt));

   // software commands carried into the back-end domain
   dsc_pulse_xfer #(.STAGES(SYNC_STAGES)) u_rst_xfer (
      .src_clk(fe_clk), .dst_clk(be_clk), .rst_n(rst_n),
      .src_pulse(sw_rst_req), .dst_pulse(be_rst_load));
   dsc_pulse_xfer #(.STAGES(SYNC_STAGES)) u_sync_xfer (
      .src_clk(fe_clk), .dst_clk(be_clk), .rst_n(rst_n),
      .src_pulse(sw_sync_req), .dst_pulse(be_sync_evt));

   // reset stretchers, reload on every request
   dsc_rst_stretch #(.CYCLES(RST_CYCLES)) u_fe_stretch (
      .clk(fe_clk), .rst_n(rst_n),
      .load(sw_rst_req | (fe_evt & fe_sync_rst_en)), .rst_out(fe_rst));
   dsc_rst_stretch #(.CYCLES(RST_CYCLES)) u_be_stretch (
      .clk(be_clk), .rst_n(rst_n),
      .load(be_rst_load), .rst_out(be_rst));

   always_ff @(posedge fe_clk or negedge rst_n) begin
      if (!rst_n) begin
         fe_stb       <= '0;
         msync_fe_stb <= 1'b0;
         fe_sout_q    <= 1'b0;
         msync_out    <= 1'b0;
      end else begin
         fe_stb       <= {FE_FN{fe_evt}} & fe_en;
         msync_fe_stb <= msf_evt;
         fe_sout_q    <= sw_sync_req;
         msync_out    <= sw_sync_req;
      end
   end

   always_ff @(posedge be_clk or negedge rst_n) begin
      if (!rst_n) begin
         be_stb       <= '0;
         msync_be_stb <= 1'b0;
         be_sout_q    <= 1'b0;
      end else begin
         be_stb       <= {BE_FN{be_evt}} & be_en;
         msync_be_stb <= msb_evt;
         be_sout_q    <= be_sync_evt;
      end
   end

   assign sout_sel = sout_sel_e'(cfg_sout_be);
   assign sync_out = (sout_sel == SOUT_BE) ? be_sout_q : fe_sout_q;
endmodule

// File: rtl/dsc_sync_ctrl_chk.sv
module dsc_sync_ctrl_chk #(
   parameter int FE_FN      = 6,
   parameter int BE_FN      = 6,
   parameter int RST_CYCLES = 10
) (
   input logic             fe_clk,
   input logic             be_clk,
   input logic             rst_n,
   input logic [FE_FN-1:0] fe_stb,
   input logic [BE_FN-1:0] be_stb,
   input logic             fe_rst,
   input logic             be_rst,
   input logic             msync_fe_stb,
   input logic             msync_be_stb
);
   logic [15:0] fe_hi, be_hi;

   always_ff @(posedge fe_clk or negedge rst_n) begin
      if (!rst_n)                fe_hi <= '0;
      else if (!fe_rst)          fe_hi <= '0;
      else if (fe_hi != 16'hFFFF) fe_hi <= fe_hi + 1'b1;
   end

   always_ff @(posedge be_clk or negedge rst_n) begin
      if (!rst_n)                be_hi <= '0;
      else if (!be_rst)          be_hi <= '0;
      else if (be_hi != 16'hFFFF) be_hi <= be_hi + 1'b1;
   end

   p_fe_stb_single_r1: assert property (@(posedge fe_clk) disable iff (!rst_n)
      (|fe_stb) |=> (fe_stb == '0));
   p_be_stb_single_r2: assert property (@(posedge be_clk) disable iff (!rst_n)
      (|be_stb) |=> (be_stb == '0));
   p_fe_rst_width_r4: assert property (@(posedge fe_clk) disable iff (!rst_n)
      $fell(fe_rst) |-> (fe_hi >= 16'(RST_CYCLES)));
   p_be_rst_width_r4: assert property (@(posedge be_clk) disable iff (!rst_n)
      $fell(be_rst) |-> (be_hi >= 16'(RST_CYCLES)));
   p_msync_fe_single_r7: assert property (@(posedge fe_clk) disable iff (!rst_n)
      msync_fe_stb |=> !msync_fe_stb);
   p_msync_be_single_r7: assert property (@(posedge be_clk) disable iff (!rst_n)
      msync_be_stb |=> !msync_be_stb);
endmodule

bind dsc_sync_ctrl dsc_sync_ctrl_chk #(
   .FE_FN(FE_FN), .BE_FN(BE_FN), .RST_CYCLES(RST_CYCLES)
) u_chk (
   .fe_clk(fe_clk), .be_clk(be_clk), .rst_n(rst_n),
   .fe_stb(fe_stb), .be_stb(be_stb), .fe_rst(fe_rst), .be_rst(be_rst),
   .msync_fe_stb(msync_fe_stb), .msync_be_stb(msync_be_stb)
);

// File: tb/tb_dsc_sync_ctrl.sv
`timescale 1ns/1ps
module tb_dsc_sync_ctrl;
   localparam int NF = 6;
   localparam int NB = 6;

   logic fe_clk = 1'b0, be_clk = 1'b0, rst_n = 1'b0;
   logic cfg_sout_be = 1'b0, fe_sync_rst_en = 1'b0;
   logic [NF-1:0] fe_en = '0;
   logic [NB-1:0] be_en = '0;
   logic sw_rst_req = 1'b0, sw_sync_req = 1'b0;
   logic fe_sync_in = 1'b0, be_sync_in = 1'b0, msync_in = 1'b0;
   logic [NF-1:0] fe_stb;
   logic [NB-1:0] be_stb;
   logic fe_rst, be_rst, msync_fe_stb, msync_be_stb, sync_out, msync_out;

   int checks = 0, failures = 0;
   int fe_hi [NF];
   int be_hi [NB];
   int fr_hi, fr_rise, br_hi, br_rise, so_fe, so_be, mo_hi, msf_hi, msb_hi;
   logic fr_q = 1'b0, br_q = 1'b0;

   always #5 fe_clk = ~fe_clk;
   always #7 be_clk = ~be_clk;

   dsc_sync_ctrl dut (
      .fe_clk(fe_clk), .be_clk(be_clk), .rst_n(rst_n), .cfg_sout_be(cfg_sout_be),
      .fe_en(fe_en), .fe_sync_rst_en(fe_sync_rst_en), .be_en(be_en),
      .sw_rst_req(sw_rst_req), .sw_sync_req(sw_sync_req),
      .fe_sync_in(fe_sync_in), .be_sync_in(be_sync_in), .msync_in(msync_in),
      .fe_stb(fe_stb), .be_stb(be_stb), .fe_rst(fe_rst), .be_rst(be_rst),
      .msync_fe_stb(msync_fe_stb), .msync_be_stb(msync_be_stb),
      .sync_out(sync_out), .msync_out(msync_out));

   always @(negedge fe_clk) begin
      for (int i = 0; i < NF; i++) fe_hi[i] += int'(fe_stb[i]);
      fr_hi  += int'(fe_rst);
      if (fe_rst && !fr_q) fr_rise++;
      fr_q   = fe_rst;
      so_fe  += int'(sync_out);
      mo_hi  += int'(msync_out);
      msf_hi += int'(msync_fe_stb);
   end

   always @(negedge be_clk) begin
      for (int i = 0; i < NB; i++) be_hi[i] += int'(be_stb[i]);
      br_hi  += int'(be_rst);
      if (be_rst && !br_q) br_rise++;
      br_q   = be_rst;
      so_be  += int'(sync_out);
      msb_hi += int'(msync_be_stb);
   end

   task automatic clear_counts();
      @(posedge fe_clk);
      for (int i = 0; i < NF; i++) fe_hi[i] = 0;
      for (int i = 0; i < NB; i++) be_hi[i] = 0;
      fr_hi = 0; fr_rise = 0; br_hi = 0; br_rise = 0;
      so_fe = 0; so_be = 0; mo_hi = 0; msf_hi = 0; msb_hi = 0;
   endtask

   task automatic check(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge fe_clk);
   endtask

   task automatic t_reset_state();
      idle(5);
      check("R9 fe_stb", int'(fe_stb), 0);
      check("R9 be_stb", int'(be_stb), 0);
      check("R9 resets", int'({fe_rst, be_rst}), 0);
      check("R9 sync outs", int'({sync_out, msync_out, msync_fe_stb, msync_be_stb}), 0);
      rst_n = 1'b1;
      idle(5);
   endtask

   task automatic t_fe_sync(logic [NF-1:0] en, logic rst_en);
      fe_en = en; fe_sync_rst_en = rst_en;
      clear_counts();
      @(negedge fe_clk) fe_sync_in = 1'b1;
      idle(6);
      fe_sync_in = 1'b0;
      idle(30);
      for (int i = 0; i < NF; i++)
         check($sformatf("R1 fe_stb[%0d] en=%b", i, en), fe_hi[i], en[i] ? 1 : 0);
      check("R3 fe_rst width from sync", fr_hi, rst_en ? 10 : 0);
   endtask

   task automatic t_be_sync(logic [NB-1:0] en);
      be_en = en;
      clear_counts();
      @(negedge fe_clk) be_sync_in = 1'b1;
      idle(6);
      be_sync_in = 1'b0;
      idle(30);
      for (int i = 0; i < NB; i++)
         check($sformatf("R2 be_stb[%0d] en=%b", i, en), be_hi[i], en[i] ? 1 : 0);
      check("R2 be_rst untouched", br_hi, 0);
   endtask

   task automatic t_sw_reset();
      clear_counts();
      @(negedge fe_clk) sw_rst_req = 1'b1;
      @(negedge fe_clk) sw_rst_req = 1'b0;
      idle(40);
      check("R4 fe_rst width", fr_hi, 10);
      check("R4 fe_rst pulses", fr_rise, 1);
      check("R4 be_rst width", br_hi, 10);
      check("R4 be_rst pulses", br_rise, 1);
   endtask

   task automatic t_restart();
      clear_counts();
      @(negedge fe_clk) sw_rst_req = 1'b1;
      @(negedge fe_clk) sw_rst_req = 1'b0;
      idle(4);
      @(negedge fe_clk) sw_rst_req = 1'b1;
      @(negedge fe_clk) sw_rst_req = 1'b0;
      idle(40);
      check("R5 fe_rst restarted width", fr_hi, 16);
      check("R5 fe_rst single pulse", fr_rise, 1);
   endtask

   task automatic t_sync_out(logic be_sel);
      cfg_sout_be = be_sel;
      clear_counts();
      @(negedge fe_clk) sw_sync_req = 1'b1;
      @(negedge fe_clk) sw_sync_req = 1'b0;
      idle(30);
      if (be_sel) check("R6 sync_out be-domain width", so_be, 1);
      else        check("R6 sync_out fe-domain width", so_fe, 1);
      check("R8 msync_out width", mo_hi, 1);
   endtask

   task automatic t_msync();
      clear_counts();
      @(negedge fe_clk) msync_in = 1'b1;
      idle(8);
      msync_in = 1'b0;
      idle(30);
      check("R7 msync_fe_stb", msf_hi, 1);
      check("R7 msync_be_stb", msb_hi, 1);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      clear_counts();
      t_reset_state();
      t_fe_sync(6'b101010, 1'b0);
      t_fe_sync(6'b010101, 1'b1);
      t_fe_sync(6'b111111, 1'b0);
      t_fe_sync(6'b000000, 1'b1);
      t_be_sync(6'b110011);
      t_be_sync(6'b001100);
      t_be_sync(6'b111111);
      t_sw_reset();
      t_restart();
      t_sync_out(1'b0);
      t_sync_out(1'b1);
      t_msync();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule